// File: doc/BRIEF.md
# Adaptive Cache Bypass Controller

This block sits beside a set-associative cache and answers one question for every miss: should the incoming line be placed in the cache, or should it go straight to the requester without displacing anything? The answer is drawn at random. The chance of a bypass is always a power of two, from certainty down to one in 4096. It is held as an exponent k, and a bypass happens when the low k bits of a free-running pseudo-random register are all zero.

For each set, the block keeps one tracking entry that remembers the most recent decision as a contest between two lines. One line was left out of the cache. This is either the bypassed newcomer or the evicted victim, and it is identified by a partial tag. The other line was kept in the cache, and it is identified by its way number. When one of these two lines is referenced later, the block learns whether the decision was good. It then doubles or halves the bypass chance and retires the entry. The caller supplies partial tags. Choosing the victim way and moving data are the caller's job.

Top module: `abyp_ctrl`

## Requirements
- R1: After reset, bypass_exp is 12, dec_valid is 0 and every tracking entry is invalid, so no hit or miss changes bypass_exp until a miss has been seen in that set.
- R2: dec_valid is 1 in exactly the cycle that follows a cycle with miss_valid high, and it is 0 after every other cycle.
- R3: The random source is a 16-bit shift register that starts at 0xACE1 after reset. It shifts left, and the new bit 0 is bit15 XOR bit13 XOR bit12 XOR bit10. It advances once per miss, after it has been used. A miss is bypassed exactly when (value AND (2^k - 1)) is 0, where k is the bypass_exp value in the cycle of the miss. When k is 0, every miss is bypassed.
- R4: A miss writes the entry of its set as valid, with a flag set to the decision and a way field set to miss_way. Its partial-tag field is miss_ptag when the miss is bypassed and miss_victim_ptag when the line is allocated.
- R5: A miss whose miss_ptag equals the partial tag of a valid entry in its set is a reference to the line that was left out. If that entry records a bypass, k rises by 1. If it records an allocation, k falls by 1.
- R6: A hit whose hit_way equals the way field of a valid entry in its set is a reference to the line that was kept. If that entry records a bypass, k falls by 1. If it records an allocation, k rises by 1. A hit that matches no valid entry changes nothing.
- R7: k saturates at 0 and at 12. When a miss adjustment and a hit adjustment happen in the same cycle, they add together before the limit is applied.
- R8: An entry that has caused an adjustment from a hit becomes invalid, so a repeated identical hit causes no further change. A miss always installs its own new entry.
- R9: When a hit and a miss target the same set in the same cycle, the hit is not compared against that entry.
- R10: A change of k appears on bypass_exp one cycle after the event that caused it. The decision for a miss uses k as it stood before that cycle's adjustment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | A miss occurs this cycle |
| miss_set | input | $clog2(SETS) | Set index of the miss |
| miss_ptag | input | PTAG_W | Partial tag of the missing line |
| miss_victim_ptag | input | PTAG_W | Partial tag of the line in the candidate victim way |
| miss_way | input | WAY_W | Candidate victim way |
| hit_valid | input | 1 | A hit occurs this cycle |
| hit_set | input | $clog2(SETS) | Set index of the hit |
| hit_way | input | WAY_W | Way that hit |
| dec_valid | output | 1 | A decision is presented for the previous cycle's miss |
| dec_bypass | output | 1 | 1 means bypass, 0 means allocate |
| bypass_exp | output | $clog2(EXP_MAX+1) | Current exponent k; the bypass chance is 2^-k |

## Verification
The bench builds the block with 4 sets, 16-bit partial tags, 4-bit ways, an exponent ceiling of 12 and a 16-bit random source. With only four sets, entries are overwritten and reused often. Partial tags are drawn from a pool of eight values, so both kinds of reference, to the line left out and to the line kept, occur often in a long random sweep. The bench also steers k to both limits to exercise saturation and the always-bypass case at k = 0. It drives same-set and cross-set events in a single cycle to show how adjustments combine and which event takes precedence.

// File: rtl/abyp_pkg.sv
package abyp_pkg;

   // Direction of one exponent adjustment.
   // ADJ_MORE raises the bypass chance (k falls), ADJ_LESS lowers it (k rises).
   typedef enum logic [1:0] {
      ADJ_NONE = 2'd0,
      ADJ_MORE = 2'd1,
      ADJ_LESS = 2'd2
   } abyp_adj_e;

   function automatic int abyp_adj_step(abyp_adj_e a);
      case (a)
         ADJ_MORE: return -1;
         ADJ_LESS: return 1;
         default:  return 0;
      endcase
   endfunction

endpackage

// File: rtl/abyp_decide.sv
module abyp_decide #(
   parameter int LFSR_W = 16,
   parameter int EXP_W  = 4,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 'hACE1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic [EXP_W-1:0] k,
   output logic             bypass
);

   logic [LFSR_W-1:0] lfsr_q;
   logic              fb;
   logic [LFSR_W-1:0] mask;

   generate
      if (LFSR_W == 16) begin : g_taps16
         assign fb = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];
      end else begin : g_taps32
         assign fb = lfsr_q[31] ^ lfsr_q[21] ^ lfsr_q[1] ^ lfsr_q[0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lfsr_q <= LFSR_SEED;
      else if (adv) lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
   end

   assign mask   = (LFSR_W'(1) << k) - LFSR_W'(1);
   assign bypass = ((lfsr_q & mask) == '0);

endmodule

// File: rtl/abyp_exp.sv
module abyp_exp
   import abyp_pkg::*;
#(
   parameter int EXP_MAX = 12,
   parameter int EXP_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  abyp_adj_e        adj_a,
   input  abyp_adj_e        adj_b,
   output logic [EXP_W-1:0] k
);

   logic [EXP_W-1:0] k_q;
   logic [EXP_W-1:0] k_d;
   int               sum;

   always_comb begin
      sum = int'(k_q) + abyp_adj_step(adj_a) + abyp_adj_step(adj_b);
      if (sum < 0)            k_d = '0;
      else if (sum > EXP_MAX) k_d = EXP_W'(EXP_MAX);
      else                    k_d = EXP_W'(sum);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) k_q <= EXP_W'(EXP_MAX);
      else        k_q <= k_d;
   end

   assign k = k_q;

endmodule

// File: rtl/abyp_track.sv
module abyp_track
   import abyp_pkg::*;
#(
   parameter int SETS   = 64,
   parameter int PTAG_W = 16,
   parameter int WAY_W  = 4,
   localparam int SET_W = $clog2(SETS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid,
   input  logic [SET_W-1:0]  miss_set,
   input  logic [PTAG_W-1:0] miss_ptag,
   input  logic [WAY_W-1:0]  miss_way,
   input  logic              wr_byp,
   input  logic [PTAG_W-1:0] wr_ptag,
   input  logic              hit_valid,
   input  logic [SET_W-1:0]  hit_set,
   input  logic [WAY_W-1:0]  hit_way,
   output abyp_adj_e         adj_miss,
   output abyp_adj_e         adj_hit
);

   logic [SETS-1:0]   ent_vld;
   logic [SETS-1:0]   ent_byp;
   logic [PTAG_W-1:0] ent_ptag [SETS];
   logic [WAY_W-1:0]  ent_way  [SETS];

   logic miss_match;
   logic hit_match;
   logic same_set;

   assign same_set   = miss_valid && (miss_set == hit_set);
   assign miss_match = miss_valid && ent_vld[miss_set] &&
                       (ent_ptag[miss_set] == miss_ptag);
   assign hit_match  = hit_valid && !same_set && ent_vld[hit_set] &&
                       (ent_way[hit_set] == hit_way);

   always_comb begin
      adj_miss = ADJ_NONE;
      if (miss_match) adj_miss = ent_byp[miss_set] ? ADJ_LESS : ADJ_MORE;
      adj_hit = ADJ_NONE;
      if (hit_match)  adj_hit  = ent_byp[hit_set]  ? ADJ_MORE : ADJ_LESS;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_vld <= '0;
      end else begin
         if (hit_match)  ent_vld[hit_set]  <= 1'b0;
         if (miss_valid) ent_vld[miss_set] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (miss_valid) begin
         ent_byp[miss_set]  <= wr_byp;
         ent_ptag[miss_set] <= wr_ptag;
         ent_way[miss_set]  <= miss_way;
      end
   end

endmodule

// File: rtl/abyp_ctrl.sv
module abyp_ctrl
   import abyp_pkg::*;
#(
   parameter int SETS    = 64,
   parameter int PTAG_W  = 16,
   parameter int WAY_W   = 4,
   parameter int EXP_MAX = 12,
   parameter int LFSR_W  = 16,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 'hACE1,
   localparam int SET_W  = $clog2(SETS),
   localparam int EXP_W  = $clog2(EXP_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid,
   input  logic [SET_W-1:0]  miss_set,
   input  logic [PTAG_W-1:0] miss_ptag,
   input  logic [PTAG_W-1:0] miss_victim_ptag,
   input  logic [WAY_W-1:0]  miss_way,
   input  logic              hit_valid,
   input  logic [SET_W-1:0]  hit_set,
   input  logic [WAY_W-1:0]  hit_way,
   output logic              dec_valid,
   output logic              dec_bypass,
   output logic [EXP_W-1:0]  bypass_exp
);

   initial begin
      assert (SETS >= 2 && (SETS & (SETS - 1)) == 0)
         else $error("SETS must be a power of two of at least 2");
      assert (LFSR_W == 16 || LFSR_W == 32)
         else $error("LFSR_W must be 16 or 32");
      assert (EXP_MAX >= 1 && EXP_MAX < LFSR_W)
         else $error("EXP_MAX must lie below LFSR_W");
      assert (LFSR_SEED != '0)
         else $error("LFSR_SEED must be nonzero");
      assert (PTAG_W >= 1 && WAY_W >= 1)
         else $error("PTAG_W and WAY_W must be positive");
   end

   logic              byp_now;
   logic [PTAG_W-1:0] wr_ptag;
   abyp_adj_e         adj_miss;
   abyp_adj_e         adj_hit;
   logic [EXP_W-1:0]  k;

   abyp_decide #(
      .LFSR_W    (LFSR_W),
      .EXP_W     (EXP_W),
      .LFSR_SEED (LFSR_SEED)
   ) decide_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (miss_valid),
      .k      (k),
      .bypass (byp_now)
   );

   assign wr_ptag = byp_now ? miss_ptag : miss_victim_ptag;

   abyp_track #(
      .SETS   (SETS),
      .PTAG_W (PTAG_W),
      .WAY_W  (WAY_W)
   ) track_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .miss_valid (miss_valid),
      .miss_set   (miss_set),
      .miss_ptag  (miss_ptag),
      .miss_way   (miss_way),
      .wr_byp     (byp_now),
      .wr_ptag    (wr_ptag),
      .hit_valid  (hit_valid),
      .hit_set    (hit_set),
      .hit_way    (hit_way),
      .adj_miss   (adj_miss),
      .adj_hit    (adj_hit)
   );

   abyp_exp #(
      .EXP_MAX (EXP_MAX),
      .EXP_W   (EXP_W)
   ) exp_i (
      .clk   (clk),
      .rst_n (rst_n),
      .adj_a (adj_miss),
      .adj_b (adj_hit),
      .k     (k)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_bypass <= 1'b0;
      end else begin
         dec_valid  <= miss_valid;
         dec_bypass <= miss_valid ? byp_now : 1'b0;
      end
   end

   assign bypass_exp = k;

endmodule

// File: rtl/abyp_ctrl_chk.sv
module abyp_ctrl_chk #(
   parameter int EXP_MAX = 12,
   parameter int EXP_W   = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             miss_valid,
   input logic             hit_valid,
   input logic             dec_valid,
   input logic             dec_bypass,
   input logic [EXP_W-1:0] bypass_exp
);

   AST_EXP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(bypass_exp) <= EXP_MAX);                                            // R7

   AST_DEC_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      miss_valid |=> dec_valid);                                               // R2

   AST_NO_SPURIOUS_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      !miss_valid |=> !dec_valid);                                             // R2

   AST_K0_ALWAYS_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && bypass_exp == '0) |=> dec_bypass);                        // R3

   AST_QUIET_HOLDS_EXP: assert property (@(posedge clk) disable iff (!rst_n)
      (!miss_valid && !hit_valid) |=> $stable(bypass_exp));                    // R10

   AST_HIT_ONLY_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_valid && !miss_valid) |=>
         (int'(bypass_exp) <= int'($past(bypass_exp)) + 1 &&
          int'($past(bypass_exp)) <= int'(bypass_exp) + 1));                   // R6

   AST_EXP_MAX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (int'(bypass_exp) <= int'($past(bypass_exp)) + 2 &&
               int'($past(bypass_exp)) <= int'(bypass_exp) + 2));              // R7

endmodule

bind abyp_ctrl abyp_ctrl_chk #(
   .EXP_MAX (EXP_MAX),
   .EXP_W   (EXP_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .miss_valid (miss_valid),
   .hit_valid  (hit_valid),
   .dec_valid  (dec_valid),
   .dec_bypass (dec_bypass),
   .bypass_exp (bypass_exp)
);

// File: tb/abyp_ctrl_tb.sv
module abyp_ctrl_tb_top;

   localparam int SETS = 4;
   localparam int PTAG_W = 16;
   localparam int WAY_W = 4;
   localparam int EXP_MAX = 12;
   localparam int SET_W = 2;
   localparam int EXP_W = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b1;
   logic              miss_valid = 1'b0;
   logic [SET_W-1:0]  miss_set = '0;
   logic [PTAG_W-1:0] miss_ptag = '0;
   logic [PTAG_W-1:0] miss_victim_ptag = '0;
   logic [WAY_W-1:0]  miss_way = '0;
   logic              hit_valid = 1'b0;
   logic [SET_W-1:0]  hit_set = '0;
   logic [WAY_W-1:0]  hit_way = '0;
   logic              dec_valid;
   logic              dec_bypass;
   logic [EXP_W-1:0]  bypass_exp;

   always #10 clk = ~clk;

   abyp_ctrl #(
      .SETS    (SETS),
      .PTAG_W  (PTAG_W),
      .WAY_W   (WAY_W),
      .EXP_MAX (EXP_MAX),
      .LFSR_W  (16)
   ) dut_i (
      .clk              (clk),
      .rst_n            (rst_n),
      .miss_valid       (miss_valid),
      .miss_set         (miss_set),
      .miss_ptag        (miss_ptag),
      .miss_victim_ptag (miss_victim_ptag),
      .miss_way         (miss_way),
      .hit_valid        (hit_valid),
      .hit_set          (hit_set),
      .hit_way          (hit_way),
      .dec_valid        (dec_valid),
      .dec_bypass       (dec_bypass),
      .bypass_exp       (bypass_exp)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // reference model state
   int          m_k;
   logic [15:0] m_lfsr;
   bit          m_vld  [SETS];
   bit          m_byp  [SETS];
   logic [15:0] m_ptag [SETS];
   logic [3:0]  m_way  [SETS];
   bit          last_dec;

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_k = EXP_MAX;
      m_lfsr = 16'hACE1;
      for (int s = 0; s < SETS; s++) m_vld[s] = 1'b0;
   endtask

   // One cycle: drive at negedge, predict, check after posedge.
   task automatic step(input bit mv, input int ms, input int mt, input int mvt, input int mw,
                       input bit hv, input int hs, input int hw, input string req);
      int          dm, dh, nk;
      bit          b;
      logic [15:0] mask;
      miss_valid = mv; miss_set = SET_W'(ms); miss_ptag = 16'(mt);
      miss_victim_ptag = 16'(mvt); miss_way = WAY_W'(mw);
      hit_valid = hv; hit_set = SET_W'(hs); hit_way = WAY_W'(hw);
      mask = (16'd1 << m_k) - 16'd1;
      b = ((m_lfsr & mask) == 16'd0);
      dm = 0; dh = 0;
      if (mv && m_vld[ms] && m_ptag[ms] == 16'(mt)) dm = m_byp[ms] ? 1 : -1;
      if (hv && !(mv && ms == hs) && m_vld[hs] && m_way[hs] == 4'(hw)) begin
         dh = m_byp[hs] ? -1 : 1;
         m_vld[hs] = 1'b0;
      end
      if (mv) begin
         m_vld[ms] = 1'b1; m_byp[ms] = b;
         m_ptag[ms] = b ? 16'(mt) : 16'(mvt); m_way[ms] = 4'(mw);
         m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
      end
      nk = m_k + dm + dh;
      if (nk < 0) nk = 0;
      if (nk > EXP_MAX) nk = EXP_MAX;
      m_k = nk;
      last_dec = b;
      @(posedge clk);
      #5;
      check("R2", "dec_valid", int'(dec_valid), int'(mv));
      if (mv) check({req, "/R3"}, "dec_bypass", int'(dec_bypass), int'(b));
      check({req, "/R10"}, "bypass_exp", int'(bypass_exp), m_k);
      @(negedge clk);
      miss_valid = 1'b0; hit_valid = 1'b0;
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 0, 0, "R10");
   endtask

   // Install an event in set s, then reference the side that raises the bypass chance.
   task automatic push_more(input int s, input string req);
      step(1, s, 16'h1000 + s, 16'h2000 + s, 2, 0, 0, 0, "R4");
      if (m_byp[s]) step(0, 0, 0, 0, 0, 1, s, 2, {req, "/R6"});
      else          step(1, s, 16'h2000 + s, 16'h3000, 5, 0, 0, 0, {req, "/R5"});
   endtask

   task automatic push_less(input int s, input string req);
      step(1, s, 16'h1100 + s, 16'h2100 + s, 3, 0, 0, 0, "R4");
      if (m_byp[s]) step(1, s, 16'h1100 + s, 16'h3100, 6, 0, 0, 0, {req, "/R5"});
      else          step(0, 0, 0, 0, 0, 1, s, 3, {req, "/R6"});
   endtask

   initial begin
      model_reset();
      #1 rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", "bypass_exp after reset", int'(bypass_exp), EXP_MAX);
      check("R1", "dec_valid after reset", int'(dec_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: no entry is valid, so hits and misses change nothing
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < 16; w++)
            step(0, 0, 0, 0, 0, 1, s, w, "R1");
      check("R1", "exp unchanged by hits", int'(bypass_exp), EXP_MAX);

      // R7: drive k to the floor and beyond
      for (int i = 0; i < EXP_MAX + 3; i++) push_more(i % SETS, "R7");
      check("R7", "floor of k", int'(bypass_exp), 0);

      // R3: at k = 0 every miss bypasses
      for (int i = 0; i < 8; i++) begin
         step(1, i % SETS, 16'h4000 + i, 16'h5000 + i, i, 0, 0, 0, "R3");
         check("R3", "k0 bypass", int'(last_dec), 1);
      end

      // R7: drive k to the ceiling and beyond
      for (int i = 0; i < EXP_MAX + 4; i++) push_less(i % SETS, "R7");
      check("R7", "ceiling of k", int'(bypass_exp), EXP_MAX);

      // R8: a repeated identical hit has no further effect
      for (int i = 0; i < 3; i++) push_more(0, "R8");
      step(1, 1, 16'h0077, 16'h0088, 9, 0, 0, 0, "R4");
      step(0, 0, 0, 0, 0, 1, 1, 9, "R8");
      step(0, 0, 0, 0, 0, 1, 1, 9, "R8");
      step(0, 0, 0, 0, 0, 1, 1, 9, "R8");

      // R9: same-set hit and miss in one cycle
      step(1, 2, 16'h0abc, 16'h0def, 7, 0, 0, 0, "R4");
      step(1, 2, 16'h0111, 16'h0222, 1, 1, 2, 7, "R9");
      step(0, 0, 0, 0, 0, 1, 2, 7, "R9");

      // R7: miss and hit adjustments in one cycle add up
      step(1, 0, 16'h0aa0, 16'h0bb0, 4, 0, 0, 0, "R4");
      step(1, 1, 16'h0aa1, 16'h0bb1, 5, 0, 0, 0, "R4");
      step(1, 0, int'(m_ptag[0]), 16'h0cc0, 8, 1, 1, 5, "R7");

      // near-exhaustive random sweep over sets, ways and a small tag pool
      for (int i = 0; i < 6000; i++) begin
         step(1'($urandom_range(0, 1)), int'($urandom_range(0, SETS - 1)),
              int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
              int'($urandom_range(0, 3)),
              1'($urandom_range(0, 1)), int'($urandom_range(0, SETS - 1)),
              int'($urandom_range(0, 3)), "R5/R6");
      end
      idle();

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete actual=0 expected=1");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule